// File: doc/BRIEF.md
# Register Rename Map Table

This block keeps the current mapping from each architectural register to the physical register that holds, or will hold, its newest value. Every map entry stores a physical tag and a ready bit. A rename request names two source registers and one destination register. In the same cycle the block returns the tag and ready state of each source. It also offers a fresh physical tag from an internal free list for the destination. On the following edge it points the destination entry at that fresh tag and marks the entry waiting.

Completing instructions broadcast their physical tag on a result port. Any entry that still holds exactly that tag becomes ready. A completion for a mapping that has since been replaced leaves the entry alone. Physical tags that a later stage no longer needs come back through a release port and are appended to the free list. When the free list is empty the block stalls renaming.

Top module: `rename_map_table`

## Requirements
- R1: After reset, architectural entry i maps to physical tag i with ready = 1, for every i in 0..15.
- R2: `src_a_tag`/`src_b_tag` show the current tags of the entries addressed by `ren_src_a`/`ren_src_b` in the same cycle, with no clock edge in between.
- R3: An accepted rename (`ren_valid` = 1, `ren_stall` = 0) writes `dst_tag` into entry `ren_dst` and clears that entry's ready bit, visible from the next cycle. A source naming the same register in the same request still sees the previous mapping.
- R4: Fresh tags are handed out first-in first-out. After reset the order is 16, 17, ..., 63, and released tags follow at the tail in release order.
- R5: A broadcast (`bc_valid` = 1) whose `bc_tag` equals an entry's current tag sets that entry ready from the next cycle.
- R6: A broadcast whose tag differs from an entry's current tag, including a stale tag of a replaced mapping, leaves that entry's ready bit and tag unchanged.
- R7: A source read in the same cycle as a broadcast of its current tag reports ready.
- R8: `ren_stall` is 1 exactly when no free tag is held. A request made while stalled changes no entry and consumes no tag.
- R9: A release (`rel_valid` = 1) adds `rel_tag` to the free list from the next cycle, so a stall clears one cycle after a release.
- R10: When a rename and a matching broadcast hit the same entry in the same cycle, the rename wins and the entry ends up not ready with the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_src_a | input | 4 | First source architectural register |
| ren_src_b | input | 4 | Second source architectural register |
| ren_dst | input | 4 | Destination architectural register |
| ren_stall | output | 1 | Free list empty; request not accepted |
| dst_tag | output | 6 | Physical tag given to the destination (valid when not stalled) |
| src_a_tag | output | 6 | Current tag of first source |
| src_a_rdy | output | 1 | First source value available |
| src_b_tag | output | 6 | Current tag of second source |
| src_b_rdy | output | 1 | Second source value available |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 6 | Physical tag of the completed result |
| rel_valid | input | 1 | Tag release valid |
| rel_tag | input | 6 | Physical tag returned to the free list |

## Verification
A corrupted map entry shows up at the source ports on the first cycle that a request names that register, so sweeping all sources after each phase exposes it within one cycle. A broken ready update appears as a source that stays waiting after its producer's broadcast, or one that turns ready after a stale broadcast, on the next read. Free-list faults appear as a wrong `dst_tag` sequence or a wrong stall edge, and show up on the first allocation after the fault.

// File: rtl/rmt_pkg.sv
// Package: default sizes shared by the rename map table and its checker.
// Assumes the physical register count is a power of two.
package rmt_pkg;
    parameter int unsigned RMT_NUM_ARCH = 16;
    parameter int unsigned RMT_NUM_PHYS = 64;
endpackage

// File: rtl/rmt_freelist.sv
// Free list of physical tags, kept as a circular FIFO.
// After reset it holds tags NUM_ARCH..NUM_PHYS-1 in ascending order.
// Assumes NUM_PHYS is a power of two and that no tag is released twice.
module rmt_freelist #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 64,
    parameter int TAG_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty
);
    localparam int FREE_N = NUM_PHYS - NUM_ARCH;
    localparam int CNT_W  = TAG_W + 1;

    logic [TAG_W-1:0] mem [NUM_PHYS];
    logic [TAG_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_pop, do_push;

    // Qualify the requests against occupancy.
    always_comb begin
        empty   = (cnt == '0);
        do_pop  = pop && !empty;
        do_push = push && (cnt != CNT_W'(NUM_PHYS));
        head_tag = mem[rd_ptr];
    end

    // Storage, pointers and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++)
                mem[i] <= (i < FREE_N) ? TAG_W'(NUM_ARCH + i) : '0;
            rd_ptr <= '0;
            wr_ptr <= TAG_W'(FREE_N);
            cnt    <= CNT_W'(FREE_N);
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_tag;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/rmt_map_entry.sv
// One map entry: a physical tag and a ready bit.
// A write installs a new tag and clears ready. A broadcast equal to the
// held tag sets ready. The write takes priority over the broadcast.
module rmt_map_entry #(
    parameter int TAG_W     = 6,
    parameter int RESET_TAG = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    output logic [TAG_W-1:0] tag,
    output logic             rdy
);
    // Entry state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag <= TAG_W'(RESET_TAG);
            rdy <= 1'b1;
        end else if (wr_en) begin
            tag <= wr_tag;
            rdy <= 1'b0;
        end else if (bc_valid && (bc_tag == tag)) begin
            rdy <= 1'b1;
        end
    end
endmodule

// File: rtl/rename_map_table.sv
// Rename map table: one entry per architectural register, a free list
// for destination tags, and same-cycle broadcast bypass on source reads.
// Assumes single-wide rename and no checkpoint recovery.
module rename_map_table #(
    parameter int NUM_ARCH = rmt_pkg::RMT_NUM_ARCH,
    parameter int NUM_PHYS = rmt_pkg::RMT_NUM_PHYS,
    parameter int ARCH_W   = $clog2(NUM_ARCH),
    parameter int TAG_W    = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [ARCH_W-1:0] ren_src_a,
    input  logic [ARCH_W-1:0] ren_src_b,
    input  logic [ARCH_W-1:0] ren_dst,
    output logic              ren_stall,
    output logic [TAG_W-1:0]  dst_tag,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic              src_a_rdy,
    output logic [TAG_W-1:0]  src_b_tag,
    output logic              src_b_rdy,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic              rel_valid,
    input  logic [TAG_W-1:0]  rel_tag
);
    logic [TAG_W-1:0]          ent_tag [NUM_ARCH];
    logic [NUM_ARCH-1:0]       ent_rdy;
    logic [NUM_ARCH*TAG_W-1:0] map_tags_flat;
    logic                      fl_empty;
    logic                      accept;

    // Accept a request only while a free tag is available.
    always_comb begin
        ren_stall = fl_empty;
        accept    = ren_valid && !fl_empty;
    end

    rmt_freelist #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .TAG_W    (TAG_W)
    ) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (accept),
        .push     (rel_valid),
        .push_tag (rel_tag),
        .head_tag (dst_tag),
        .empty    (fl_empty)
    );

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
        logic wr_sel;
        assign wr_sel = accept && (ren_dst == ARCH_W'(g));
        rmt_map_entry #(
            .TAG_W     (TAG_W),
            .RESET_TAG (g)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel),
            .wr_tag   (dst_tag),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .tag      (ent_tag[g]),
            .rdy      (ent_rdy[g])
        );
        assign map_tags_flat[g*TAG_W +: TAG_W] = ent_tag[g];
    end

    // Source lookup with bypass from a same-cycle broadcast.
    always_comb begin
        src_a_tag = ent_tag[ren_src_a];
        src_b_tag = ent_tag[ren_src_b];
        src_a_rdy = ent_rdy[ren_src_a] | (bc_valid && (bc_tag == src_a_tag));
        src_b_rdy = ent_rdy[ren_src_b] | (bc_valid && (bc_tag == src_b_tag));
    end
endmodule

// File: rtl/rmt_checker.sv
// Property checker for the rename map table, bound into every instance.
// It sees the table state through the internal tag and ready vectors.
module rmt_checker #(
    parameter int NUM_ARCH = 16,
    parameter int ARCH_W   = 4,
    parameter int TAG_W    = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ren_valid,
    input logic [ARCH_W-1:0]         ren_src_a,
    input logic [ARCH_W-1:0]         ren_dst,
    input logic                      ren_stall,
    input logic [TAG_W-1:0]          dst_tag,
    input logic [TAG_W-1:0]          src_a_tag,
    input logic                      src_a_rdy,
    input logic                      bc_valid,
    input logic [TAG_W-1:0]          bc_tag,
    input logic [NUM_ARCH*TAG_W-1:0] tags_flat,
    input logic [NUM_ARCH-1:0]       rdy_vec
);
    logic [TAG_W-1:0]          t_arr [NUM_ARCH];
    logic                      past_ok, p_acc, p_stall, p_bcv, p_src_rdy;
    logic [ARCH_W-1:0]         p_dst, p_src;
    logic [TAG_W-1:0]          p_new, p_bct, p_src_tag;
    logic [NUM_ARCH*TAG_W-1:0] p_tags;

    // Unpack the flat tag vector.
    always_comb
        for (int i = 0; i < NUM_ARCH; i++) t_arr[i] = tags_flat[i*TAG_W +: TAG_W];

    // Remember the previous cycle's request and state.
    always_ff @(posedge clk) begin
        past_ok   <= rst_n;
        p_acc     <= ren_valid && !ren_stall;
        p_stall   <= ren_stall;
        p_dst     <= ren_dst;
        p_new     <= dst_tag;
        p_bcv     <= bc_valid;
        p_bct     <= bc_tag;
        p_src     <= ren_src_a;
        p_src_tag <= t_arr[ren_src_a];
        p_src_rdy <= rdy_vec[ren_src_a];
        p_tags    <= tags_flat;
    end

    // R3 R10
    rename_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_acc) |-> (t_arr[p_dst] == p_new && !rdy_vec[p_dst]));

    // R5
    bcast_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_bcv && p_bct == p_src_tag && !(p_acc && p_dst == p_src))
        |-> rdy_vec[p_src]);

    // R6
    stale_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !p_src_rdy && !(p_bcv && p_bct == p_src_tag) && !(p_acc && p_dst == p_src))
        |-> (!rdy_vec[p_src] && t_arr[p_src] == p_src_tag));

    // R7
    bypass_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && bc_tag == src_a_tag) |-> src_a_rdy);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_stall) |-> (tags_flat == p_tags));
endmodule

bind rename_map_table rmt_checker #(
    .NUM_ARCH (NUM_ARCH),
    .ARCH_W   (ARCH_W),
    .TAG_W    (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ren_valid (ren_valid),
    .ren_src_a (ren_src_a),
    .ren_dst   (ren_dst),
    .ren_stall (ren_stall),
    .dst_tag   (dst_tag),
    .src_a_tag (src_a_tag),
    .src_a_rdy (src_a_rdy),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .tags_flat (map_tags_flat),
    .rdy_vec   (ent_rdy)
);

// File: tb/sim_rename_map_table.sv
`timescale 1ns/1ps
// Bench: drives rename, broadcast and release patterns and compares every
// output against a behavioural model of the requirements.
module sim_rename_map_table;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic [3:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic       ren_stall, src_a_rdy, src_b_rdy;
    logic [5:0] dst_tag, src_a_tag, src_b_tag;
    logic       bc_valid = 1'b0, rel_valid = 1'b0;
    logic [5:0] bc_tag = '0, rel_tag = '0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // model state
    int m_tag [16];
    bit m_rdy [16];
    int fq [64];
    int f_head, f_cnt;

    always #2.5 clk = ~clk;

    rename_map_table u0 (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_stall(ren_stall), .dst_tag(dst_tag),
        .src_a_tag(src_a_tag), .src_a_rdy(src_a_rdy),
        .src_b_tag(src_b_tag), .src_b_rdy(src_b_rdy),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .rel_valid(rel_valid), .rel_tag(rel_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check, then advance the model.
    task automatic step(input string req, input bit v, input int dst, input int sa, input int sb,
                        input bit bcv, input int bct, input bit relv, input int relt);
        bit acc;
        int newt;
        @(negedge clk);
        ren_valid = v; ren_dst = 4'(dst); ren_src_a = 4'(sa); ren_src_b = 4'(sb);
        bc_valid = bcv; bc_tag = 6'(bct); rel_valid = relv; rel_tag = 6'(relt);
        #1;
        chk({req, " R8"}, "stall", int'(ren_stall), int'(f_cnt == 0));
        if (f_cnt != 0) chk({req, " R4"}, "dst_tag", int'(dst_tag), fq[f_head]);
        chk({req, " R2"}, "src_a_tag", int'(src_a_tag), m_tag[sa]);
        chk({req, " R2"}, "src_b_tag", int'(src_b_tag), m_tag[sb]);
        chk({req, " R7"}, "src_a_rdy", int'(src_a_rdy), int'(m_rdy[sa] | (bcv && bct == m_tag[sa])));
        chk({req, " R7"}, "src_b_rdy", int'(src_b_rdy), int'(m_rdy[sb] | (bcv && bct == m_tag[sb])));
        @(posedge clk);
        acc  = v && (f_cnt != 0);
        newt = fq[f_head];
        for (int e = 0; e < 16; e++) begin
            if (acc && e == dst) begin m_tag[e] = newt; m_rdy[e] = 0; end
            else if (bcv && bct == m_tag[e]) m_rdy[e] = 1;
        end
        if (relv) fq[(f_head + f_cnt) % 64] = relt;
        if (acc) f_head = (f_head + 1) % 64;
        f_cnt = f_cnt + int'(relv) - int'(acc);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 16; a++) step(req, 0, 0, a, 15 - a, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_tag[i] = i; m_rdy[i] = 1; end
        for (int i = 0; i < 64; i++) fq[i] = (i < 48) ? 16 + i : 0;
        f_head = 0; f_cnt = 48;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        sweep("R1");                                   // reset mapping
        for (int i = 0; i < 16; i++)                   // R3 R4 back-to-back chain
            step("R3", 1, i, (i + 15) % 16, i, 0, 0, 0, 0);
        sweep("R3");
        step("R7", 0, 0, 0, 1, 1, 16, 0, 0);           // bypass on tag 16
        step("R5", 0, 0, 0, 1, 0, 0, 0, 0);            // entry 0 now ready
        step("R6", 1, 3, 3, 3, 0, 0, 0, 0);            // r3: 19 -> 32
        step("R6", 0, 0, 3, 4, 1, 19, 0, 0);           // stale broadcast
        step("R6", 0, 0, 3, 4, 0, 0, 0, 0);
        step("R5", 0, 0, 3, 4, 1, 32, 0, 0);
        step("R5", 0, 0, 3, 4, 0, 0, 0, 0);
        step("R10", 1, 5, 5, 5, 1, 21, 0, 0);          // rename beats broadcast
        step("R10", 0, 0, 5, 5, 0, 0, 0, 0);
        for (int k = 0; f_cnt > 0 && k < 100; k++)    // drain free list
            step("R4", 1, k % 16, (k + 7) % 16, k % 16, 0, 0, 0, 0);
        step("R8", 1, 7, 7, 2, 0, 0, 0, 0);            // stalled request
        step("R8", 1, 7, 7, 2, 0, 0, 0, 0);
        sweep("R8");
        step("R9", 0, 0, 0, 0, 0, 0, 1, 5);            // release tag 5
        step("R9", 0, 0, 0, 0, 0, 0, 1, 19);           // release tag 19
        step("R9", 1, 9, 9, 9, 0, 0, 0, 0);            // gets 5
        step("R9", 1, 9, 9, 9, 0, 0, 0, 0);            // gets 19
        step("R9", 1, 9, 9, 9, 0, 0, 0, 0);            // stalled again
        sweep("R9");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule